// File: doc/BRIEF.md
# Hashed page table search engine

This block turns a 32-bit effective address into a 32-bit physical address. It takes the upper four address bits to choose one of sixteen segment registers, which supplies a 24-bit virtual segment identifier (VSID). The VSID, the 16-bit page index and the 12-bit byte offset together make up a 52-bit virtual address. The block hashes the VSID and page index into the address of a 64-byte group of eight 8-byte page table entries. It then reads those entries one at a time through a single-outstanding memory read port and compares each against the request.

If no entry in the primary group matches, the search repeats in a secondary group whose hash is the complement of the primary hash. If that also fails, the result is a page fault. The table base and its power-of-two size come from configuration inputs. If translation is disabled for the request's kind (instruction fetch or data access), the effective address is returned unchanged. A request is taken only while the block is idle. The requester keeps its inputs steady until the one-cycle completion pulse.

Top module: `hpt_walker`

## Requirements
- R1: A write with `seg_we` high loads `seg_vsid` into segment register `seg_sel`. A request uses the register selected by `req_ea[31:28]`, as it stands at acceptance.
- R2: When the enable bit for the request kind is clear (`msr_ir` when `req_fetch`=1, `msr_dr` when `req_fetch`=0), no memory read is issued. `done` pulses in the cycle after acceptance with `done_pa` equal to `req_ea` and `done_fault`=0.
- R3: The primary hash is `vsid[18:0] XOR {3'b0, ea[27:12]}`. The first read address is `(tbl_base & ~M) | ({7'b0, hash, 6'b0} & M)`, where M = 2^L − 1.
- R4: Reads go out one at a time. `mem_rd_en` is a one-cycle pulse, and the next pulse waits for `mem_rd_valid`. Entry k of a group is read at group address + 8·k, for k = 0 to 7 in order.
- R5: The entry layout is: bit 63 valid, bits 62:39 VSID, bit 38 hash-select, bits 37:32 abbreviated page index, bits 31:12 physical page number. An entry matches only when it is valid, its VSID equals the request VSID, its abbreviated index equals `ea[27:22]`, and its hash-select equals 0 in the primary group or 1 in the secondary group.
- R6: The search stops at the first matching entry. The result is `done_pa = {ppn, ea[11:0]}` with `done_fault`=0. No further reads follow the match.
- R7: After eight misses in the primary group, the search reads the secondary group. The secondary hash is the ones' complement of the primary hash, placed the same way as in R3.
- R8: After sixteen misses, `done` pulses with `done_fault`=1 and `done_pa`=0.
- R9: `done` is high for exactly one cycle per accepted request. `req_ready` is high only while idle. A `req_valid` raised during a search is ignored and starts no work.
- R10: L is `tbl_lg2` clamped to the range 16 to 25. Hash bits above the table size are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_we | input | 1 | Segment register write strobe |
| seg_sel | input | 4 | Segment register index for the write |
| seg_vsid | input | 24 | VSID value to write |
| tbl_base | input | 32 | Page table base address, aligned to the table size |
| tbl_lg2 | input | 5 | Log2 of the table size in bytes |
| req_valid | input | 1 | Translation request |
| req_ea | input | 32 | Effective address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| msr_ir | input | 1 | Instruction translation enable |
| msr_dr | input | 1 | Data translation enable |
| req_ready | output | 1 | High while idle, when a request can be accepted |
| mem_rd_en | output | 1 | Read strobe for one 8-byte entry |
| mem_rd_addr | output | 32 | Entry byte address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Page table entry |
| done | output | 1 | One-cycle completion pulse |
| done_pa | output | 32 | Physical address (0 on a fault) |
| done_fault | output | 1 | Page fault flag |

## Verification
Directed cases place the matching entry at slot 0, behind decoys that each miss on a single field, twice in one group, only in the secondary group, or nowhere. The read count and the first read address then show whether the entry order, the field compare, first-match stopping and the fallback to the secondary group are each correct. Pass-through requests with each enable bit cleared separate the fetch and data paths. A larger table size with a high table base checks the size masking of the hash. Random requests over varied segments, with entries placed at random slots in either group and random memory latency, are compared against a bench search model, and one request raised during a search checks that busy-time requests are ignored.

// File: rtl/hpt_pkg.sv
// Shared widths and field positions for the hashed page table search engine.
// Assumes 4-Kbyte pages, 256-Mbyte segments and 8-byte entries in 64-byte groups.
package hpt_pkg;
    localparam int EA_W      = 32;
    localparam int VSID_W    = 24;
    localparam int OFF_W     = 12;
    localparam int SEG_SEL_W = 4;
    localparam int PIDX_W    = EA_W - SEG_SEL_W - OFF_W;   // 16
    localparam int HASH_W    = 19;
    localparam int API_W     = 6;
    localparam int PPN_W     = EA_W - OFF_W;               // 20
    localparam int PTE_W     = 64;
    localparam int GROUP_N   = 8;
    localparam int ENT_W     = $clog2(GROUP_N);            // 3
    localparam int PTE_BYTES = PTE_W / 8;
    localparam int GRP_ALIGN = $clog2(GROUP_N * PTE_BYTES); // 6
    localparam int LG_MIN    = 16;
    localparam int LG_MAX    = HASH_W + GRP_ALIGN;         // 25
    localparam int NSEG      = 1 << SEG_SEL_W;

    // Field positions inside a page table entry
    localparam int PTE_V_BIT   = 63;
    localparam int PTE_VSID_LO = 39;
    localparam int PTE_H_BIT   = 38;
    localparam int PTE_API_LO  = 32;
    localparam int PTE_PPN_LO  = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FIN   = 2'd3
    } walk_st_e;
endpackage

// File: rtl/hpt_seg_file.sv
// Sixteen segment registers, each holding a VSID.
// One synchronous write port and one combinational read port; reset clears all entries.
module hpt_seg_file
    import hpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEG_SEL_W-1:0] wr_sel,
    input  logic [VSID_W-1:0]    wr_vsid,
    input  logic [SEG_SEL_W-1:0] rd_sel,
    output logic [VSID_W-1:0]    rd_vsid
);
    logic [VSID_W-1:0] seg_q [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        // Hold one segment register, loaded when its index is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_q[g] <= '0;
            else if (wr_en && wr_sel == SEG_SEL_W'(g))
                seg_q[g] <= wr_vsid;
        end
    end

    // Select the VSID for the requested segment
    assign rd_vsid = seg_q[rd_sel];

    // The register written in one cycle reads back that value in the next
    p_seg_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_sel == wr_sel) |=> (rd_vsid == $past(wr_vsid)));
endmodule

// File: rtl/hpt_pteg_hash.sv
// Forms the address of a 64-byte entry group from the VSID and page index.
// Assumes the table base is aligned to the table size; the size is clamped to the legal range.
module hpt_pteg_hash
    import hpt_pkg::*;
(
    input  logic [VSID_W-1:0] vsid,
    input  logic [PIDX_W-1:0] pidx,
    input  logic              second,
    input  logic [EA_W-1:0]   tbl_base,
    input  logic [4:0]        tbl_lg2,
    output logic [EA_W-1:0]   grp_addr
);
    logic [HASH_W-1:0] h_prim;
    logic [HASH_W-1:0] h_sel;
    logic [4:0]        lg_eff;
    logic [EA_W-1:0]   span;
    logic [EA_W-1:0]   size_mask;

    // Primary hash, complemented for the secondary group
    always_comb begin
        h_prim = vsid[HASH_W-1:0] ^ {{(HASH_W-PIDX_W){1'b0}}, pidx};
        h_sel  = second ? ~h_prim : h_prim;
    end

    // Clamp the table size to what the hash can cover
    always_comb begin
        if (tbl_lg2 < 5'(LG_MIN))
            lg_eff = 5'(LG_MIN);
        else if (tbl_lg2 > 5'(LG_MAX))
            lg_eff = 5'(LG_MAX);
        else
            lg_eff = tbl_lg2;
    end

    // Mask the shifted hash to the table size and merge it into the base
    always_comb begin
        span      = {{(EA_W-HASH_W-GRP_ALIGN){1'b0}}, h_sel, {GRP_ALIGN{1'b0}}};
        size_mask = (EA_W'(1) << lg_eff) - EA_W'(1);
        grp_addr  = (tbl_base & ~size_mask) | (span & size_mask);
    end
endmodule

// File: rtl/hpt_pte_cmp.sv
// Compares one page table entry with the request and extracts its physical page number.
// Purely combinational; the caller qualifies the result with read-data valid.
module hpt_pte_cmp
    import hpt_pkg::*;
(
    input  logic [PTE_W-1:0]  pte,
    input  logic [VSID_W-1:0] vsid,
    input  logic [API_W-1:0]  api,
    input  logic              second,
    output logic              hit,
    output logic [PPN_W-1:0]  ppn
);
    // Match on valid, VSID, abbreviated index and hash-select
    always_comb begin
        hit = pte[PTE_V_BIT]
           && (pte[PTE_VSID_LO +: VSID_W] == vsid)
           && (pte[PTE_API_LO +: API_W] == api)
           && (pte[PTE_H_BIT] == second);
        ppn = pte[PTE_PPN_LO +: PPN_W];
    end
endmodule

// File: rtl/hpt_walker.sv
// Translates an effective address by a segment lookup and a primary then secondary
// hashed group search, one entry read at a time. Assumes the requester holds its inputs
// until done, and that memory answers each read with exactly one valid beat.
module hpt_walker
    import hpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seg_we,
    input  logic [SEG_SEL_W-1:0] seg_sel,
    input  logic [VSID_W-1:0]    seg_vsid,
    input  logic [EA_W-1:0]      tbl_base,
    input  logic [4:0]           tbl_lg2,
    input  logic                 req_valid,
    input  logic [EA_W-1:0]      req_ea,
    input  logic                 req_fetch,
    input  logic                 msr_ir,
    input  logic                 msr_dr,
    output logic                 req_ready,
    output logic                 mem_rd_en,
    output logic [EA_W-1:0]      mem_rd_addr,
    input  logic                 mem_rd_valid,
    input  logic [PTE_W-1:0]     mem_rd_data,
    output logic                 done,
    output logic [EA_W-1:0]      done_pa,
    output logic                 done_fault
);
    walk_st_e          st_q;
    logic [EA_W-1:0]   ea_q;
    logic [VSID_W-1:0] vsid_q;
    logic              sec_q;
    logic [ENT_W-1:0]  ent_q;
    logic [EA_W-1:0]   pa_q;
    logic              fault_q;

    logic [VSID_W-1:0] seg_rd_vsid;
    logic [EA_W-1:0]   grp_addr;
    logic              pte_hit;
    logic [PPN_W-1:0]  pte_ppn;
    logic              xlate_on;
    logic              accept;

    hpt_seg_file u_seg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_we),
        .wr_sel  (seg_sel),
        .wr_vsid (seg_vsid),
        .rd_sel  (req_ea[EA_W-1 -: SEG_SEL_W]),
        .rd_vsid (seg_rd_vsid)
    );

    hpt_pteg_hash u_hash (
        .vsid     (vsid_q),
        .pidx     (ea_q[OFF_W +: PIDX_W]),
        .second   (sec_q),
        .tbl_base (tbl_base),
        .tbl_lg2  (tbl_lg2),
        .grp_addr (grp_addr)
    );

    hpt_pte_cmp u_cmp (
        .pte    (mem_rd_data),
        .vsid   (vsid_q),
        .api    (ea_q[OFF_W + PIDX_W - API_W +: API_W]),
        .second (sec_q),
        .hit    (pte_hit),
        .ppn    (pte_ppn)
    );

    // Decode acceptance and whether this request kind is translated
    always_comb begin
        xlate_on = req_fetch ? msr_ir : msr_dr;
        accept   = req_valid && (st_q == ST_IDLE);
    end

    // Search state machine: accept, issue a read, judge the entry, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            ea_q    <= '0;
            vsid_q  <= '0;
            sec_q   <= 1'b0;
            ent_q   <= '0;
            pa_q    <= '0;
            fault_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        ea_q    <= req_ea;
                        vsid_q  <= seg_rd_vsid;
                        sec_q   <= 1'b0;
                        ent_q   <= '0;
                        fault_q <= 1'b0;
                        if (xlate_on) begin
                            st_q <= ST_ISSUE;
                        end else begin
                            pa_q <= req_ea;
                            st_q <= ST_FIN;
                        end
                    end
                end
                ST_ISSUE: st_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rd_valid) begin
                        if (pte_hit) begin
                            pa_q <= {pte_ppn, ea_q[OFF_W-1:0]};
                            st_q <= ST_FIN;
                        end else if (ent_q != ENT_W'(GROUP_N - 1)) begin
                            ent_q <= ent_q + ENT_W'(1);
                            st_q  <= ST_ISSUE;
                        end else if (!sec_q) begin
                            sec_q <= 1'b1;
                            ent_q <= '0;
                            st_q  <= ST_ISSUE;
                        end else begin
                            pa_q    <= '0;
                            fault_q <= 1'b1;
                            st_q    <= ST_FIN;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the read port and the completion outputs from the state
    always_comb begin
        req_ready   = (st_q == ST_IDLE);
        mem_rd_en   = (st_q == ST_ISSUE);
        mem_rd_addr = grp_addr | {{(EA_W-ENT_W-3){1'b0}}, ent_q, 3'b000};
        done        = (st_q == ST_FIN);
        done_pa     = pa_q;
        done_fault  = fault_q;
    end

    // Completion lasts exactly one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // No reads while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_en);
    // Only one read in flight: a strobe is never followed directly by another
    p_single_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);
    // Entry reads are 8-byte aligned
    p_read_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_rd_addr[2:0] == 3'b000));
    // A fault reports a zero address
    p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault) |-> (done_pa == '0));
    // A pass-through completes the cycle after acceptance
    p_bypass_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !xlate_on) |=> (done && done_pa == $past(req_ea)));
endmodule

// File: tb/hpt_walker_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random requests against a search model.
module hpt_walker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [3:0]  seg_sel = '0;
    logic [23:0] seg_vsid = '0;
    logic [31:0] tbl_base = 32'h0012_0000;
    logic [4:0]  tbl_lg2 = 5'd16;
    logic        req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic        req_fetch = 1'b0;
    logic        msr_ir = 1'b1;
    logic        msr_dr = 1'b1;
    logic        req_ready;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic        done;
    logic [31:0] done_pa;
    logic        done_fault;

    int n_checks = 0;
    int n_fail   = 0;

    logic [63:0] mem [logic [31:0]];
    logic [23:0] seg_m [16];

    int          n_reads = 0;
    logic [31:0] first_addr = '0;
    int          n_done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_sel(seg_sel), .seg_vsid(seg_vsid),
        .tbl_base(tbl_base), .tbl_lg2(tbl_lg2), .req_valid(req_valid), .req_ea(req_ea),
        .req_fetch(req_fetch), .msr_ir(msr_ir), .msr_dr(msr_dr), .req_ready(req_ready),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .done(done), .done_pa(done_pa), .done_fault(done_fault)
    );

    // Memory responder with random latency, and read/done counters at the ports
    logic        pend = 1'b0;
    int          lat = 0;
    logic [31:0] paddr = '0;
    always @(negedge clk) begin
        mem_rd_valid = 1'b0;
        if (pend) begin
            if (lat == 0) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = mem.exists(paddr) ? mem[paddr] : 64'd0;
                pend = 1'b0;
            end else begin
                lat = lat - 1;
            end
        end
        if (mem_rd_en) begin
            pend  = 1'b1;
            paddr = mem_rd_addr;
            lat   = int'($urandom % 3);
            n_reads++;
            if (n_reads == 1) first_addr = mem_rd_addr;
        end
        if (done) n_done++;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected finished)");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_pte(input logic v, input logic [23:0] vs, input logic h,
                                           input logic [5:0] api, input logic [19:0] ppn);
        return {v, vs, h, api, ppn, 12'd0};
    endfunction

    // Group address per R3/R7/R10
    function automatic logic [31:0] grp_of(input logic [23:0] vs, input logic [31:0] ea, input logic sec);
        logic [18:0] h;
        logic [31:0] m;
        int lg;
        h = vs[18:0] ^ {3'b0, ea[27:12]};
        if (sec) h = ~h;
        lg = int'(tbl_lg2);
        if (lg < 16) lg = 16;
        if (lg > 25) lg = 25;
        m = (32'd1 << lg) - 32'd1;
        return (tbl_base & ~m) | ({7'd0, h, 6'd0} & m);
    endfunction

    // Search model per R2, R5-R8
    task automatic model(input logic [31:0] ea, input logic fetch, output logic [31:0] pa,
                         output logic flt, output int nrd, output logic [31:0] fa);
        logic [23:0] vs;
        logic [63:0] p;
        logic [31:0] a;
        logic on;
        on = fetch ? msr_ir : msr_dr;
        pa = ea; flt = 1'b0; nrd = 0; fa = 32'd0;
        if (!on) return;
        vs = seg_m[ea[31:28]];
        fa = grp_of(vs, ea, 1'b0);
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 8; k++) begin
                a = grp_of(vs, ea, s[0]) | (32'(k) << 3);
                p = mem.exists(a) ? mem[a] : 64'd0;
                nrd++;
                if (p[63] && p[62:39] == vs && p[37:32] == ea[27:22] && p[38] == s[0]) begin
                    pa = {p[31:12], ea[11:0]};
                    return;
                end
            end
        end
        pa = 32'd0; flt = 1'b1;
    endtask

    task automatic wr_seg(input logic [3:0] s, input logic [23:0] v);
        @(negedge clk);
        seg_we = 1'b1; seg_sel = s; seg_vsid = v;
        @(negedge clk);
        seg_we = 1'b0;
        seg_m[s] = v;
    endtask

    // Issue one request, wait for done; optionally raise req_valid mid-search
    task automatic apply(input string tag, input logic [31:0] ea, input logic fetch,
                         input logic poke_busy);
        logic [31:0] e_pa, e_fa;
        logic e_flt;
        int e_nrd, waited, done_before;
        model(ea, fetch, e_pa, e_flt, e_nrd, e_fa);
        @(negedge clk);
        n_reads = 0; first_addr = '0;
        req_ea = ea; req_fetch = fetch; req_valid = 1'b1;
        done_before = n_done;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (!done) begin
            if (poke_busy && waited == 2) begin
                req_valid = 1'b1;
                @(negedge clk);
                req_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
            waited++;
        end
        chk({tag, " pa"}, done_pa, e_pa);
        chk({tag, " fault"}, {31'd0, done_fault}, {31'd0, e_flt});
        chk({tag, " reads"}, 32'(n_reads), 32'(e_nrd));
        if (e_nrd > 0) chk({tag, " first addr R3"}, first_addr, e_fa);
        if (e_nrd == 0) chk({tag, " latency R2"}, 32'(waited), 32'd0);
        if (poke_busy) begin
            repeat (5) @(negedge clk);
            chk({tag, " done count R9"}, 32'(n_done - done_before), 32'd1);
            chk({tag, " no extra reads R9"}, 32'(n_reads), 32'(e_nrd));
            chk({tag, " ready R9"}, {31'd0, req_ready}, 32'd1);
        end
    endtask

    initial begin
        logic [31:0] ea, g0, g1;
        void'($urandom(32'd12345));
        for (int i = 0; i < 16; i++) seg_m[i] = '0;
        repeat (3) @(negedge clk);
        // Reset state
        chk("reset ready R9", {31'd0, req_ready}, 32'd1);
        chk("reset done R9", {31'd0, done}, 32'd0);
        chk("reset rd_en R4", {31'd0, mem_rd_en}, 32'd0);
        rst_n = 1'b1;

        wr_seg(4'd3, 24'hABCDE1);
        wr_seg(4'd5, 24'h13579B);
        ea = 32'h3456_7ABC;
        g0 = grp_of(24'hABCDE1, ea, 1'b0);
        g1 = grp_of(24'hABCDE1, ea, 1'b1);

        // R2: pass-through for fetch and for data
        msr_ir = 1'b0; msr_dr = 1'b1;
        apply("R2 fetch bypass", ea, 1'b1, 1'b0);
        msr_ir = 1'b1; msr_dr = 1'b0;
        apply("R2 data bypass", ea, 1'b0, 1'b0);
        msr_dr = 1'b1;

        // R3/R5/R6: hit at entry 0 of the primary group
        mem[g0] = mk_pte(1'b1, 24'hABCDE1, 1'b0, ea[27:22], 20'hCAFE1);
        apply("R6 hit slot0", ea, 1'b0, 1'b0);
        chk("R6 slot0 pa value", done_pa, 32'hCAFE_1ABC);

        // R5: decoys each missing one field, match at entry 5
        mem.delete();
        mem[g0 + 0]  = mk_pte(1'b0, 24'hABCDE1, 1'b0, ea[27:22], 20'h11111);
        mem[g0 + 8]  = mk_pte(1'b1, 24'hABCDE1, 1'b0, ~ea[27:22], 20'h22222);
        mem[g0 + 16] = mk_pte(1'b1, 24'hABCDE1, 1'b1, ea[27:22], 20'h33333);
        mem[g0 + 24] = mk_pte(1'b1, 24'hABCDE0, 1'b0, ea[27:22], 20'h44444);
        mem[g0 + 40] = mk_pte(1'b1, 24'hABCDE1, 1'b0, ea[27:22], 20'h55555);
        apply("R5 decoys", ea, 1'b1, 1'b0);
        chk("R5 decoy read count", 32'(n_reads), 32'd6);

        // R6: two matches, first wins
        mem.delete();
        mem[g0 + 16] = mk_pte(1'b1, 24'hABCDE1, 1'b0, ea[27:22], 20'hAAAAA);
        mem[g0 + 32] = mk_pte(1'b1, 24'hABCDE1, 1'b0, ea[27:22], 20'hBBBBB);
        apply("R6 first match", ea, 1'b0, 1'b0);
        chk("R6 first match pa", done_pa, 32'hAAAA_AABC);

        // R7: match only in secondary group at entry 3 (primary H=0 copy absent)
        mem.delete();
        mem[g0 + 8]  = mk_pte(1'b1, 24'hABCDE1, 1'b1, ea[27:22], 20'h0DEAD);
        mem[g1 + 24] = mk_pte(1'b1, 24'hABCDE1, 1'b1, ea[27:22], 20'h0BEEF);
        apply("R7 secondary", ea, 1'b0, 1'b0);
        chk("R7 secondary reads", 32'(n_reads), 32'd12);
        chk("R7 secondary pa", done_pa, 32'h0BEE_FABC);

        // R8: fault after sixteen misses
        mem.delete();
        mem[g1] = mk_pte(1'b1, 24'hABCDE1, 1'b0, ea[27:22], 20'h12345);
        apply("R8 fault", ea, 1'b0, 1'b0);
        chk("R8 fault reads", 32'(n_reads), 32'd16);

        // R10: larger table at a high base
        tbl_base = 32'h0300_0000; tbl_lg2 = 5'd24;
        mem.delete();
        ea = 32'h5FED_C123;
        mem[grp_of(24'h13579B, ea, 1'b0) + 8] = mk_pte(1'b1, 24'h13579B, 1'b0, ea[27:22], 20'h7F00F);
        apply("R10 big table", ea, 1'b0, 1'b0);
        tbl_lg2 = 5'd31;
        apply("R10 clamp high", ea, 1'b0, 1'b0);

        // R9: request raised during a search is ignored
        apply("R9 busy poke", ea, 1'b0, 1'b1);

        // R1: rewrite segment and see the new VSID used
        wr_seg(4'd5, 24'h2468AC);
        tbl_base = 32'h0012_0000; tbl_lg2 = 5'd16;
        mem.delete();
        mem[grp_of(24'h2468AC, ea, 1'b0)] = mk_pte(1'b1, 24'h2468AC, 1'b0, ea[27:22], 20'h00AB1);
        apply("R1 segment rewrite", ea, 1'b0, 1'b0);

        // Random requests
        for (int n = 0; n < N_RANDOM; n++) begin
            logic [3:0] s;
            logic [23:0] vs;
            logic sec;
            logic [2:0] k;
            logic [31:0] g;
            if (n % 10 == 0) wr_seg(4'($urandom), 24'($urandom));
            tbl_lg2 = 5'(16 + ($urandom % 10));
            tbl_base = 32'($urandom) & 32'hFE00_0000;
            ea = 32'($urandom);
            s = ea[31:28];
            vs = seg_m[s];
            mem.delete();
            for (int d = 0; d < 4; d++)
                mem[grp_of(vs, ea, d[0]) | (32'($urandom % 8) << 3)] =
                    mk_pte(1'($urandom), vs, 1'($urandom), ea[27:22] ^ 6'($urandom % 2), 20'($urandom));
            sec = 1'($urandom);
            k = 3'($urandom);
            g = grp_of(vs, ea, sec) | {29'd0, k} << 3;
            if ($urandom % 4 != 0) mem[g] = mk_pte(1'b1, vs, sec, ea[27:22], 20'($urandom));
            msr_ir = ($urandom % 8) != 0;
            msr_dr = ($urandom % 8) != 0;
            apply("R6 random", ea, 1'($urandom), 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule